// File: doc/BRIEF.md
# Queue Starvation Watchdog with Run Length

This block watches three traffic queues of a memory controller: high-priority reads, low-priority reads and writes. Each queue has its own watchdog. The watchdog counts the controller clocks in which the queue holds pending transactions but none of them is serviced. When that count reaches the queue's programmed limit, the queue's critical flag rises.

A queue that has gone critical keeps its flag high until it has been granted a bounded service quota. The quota is fixed at the moment the flag rises. It is the smaller of the programmed run length and the number of transactions pending at that moment. A starve limit of zero switches the watchdog off for that queue.

Each queue's critical flag goes to an arbiter outside this block, which decides among the critical queues and issues commands. Both of those jobs are outside this block.

Top module: `queue_starve_guard`

## Requirements
- R1: While reset is held, and in the first cycle after reset is released, every critical flag is 0.
- R2: A clock cycle is starved when the queue's pending count is non-zero and its service pulse is 0. With a non-zero limit L, the critical flag rises at the clock edge that ends the L-th starved cycle in a row. It is still 0 after L-1 such cycles.
- R3: A queue whose starve limit is 0 never raises its critical flag, however long it stays starved.
- R4: A service pulse restarts the starved count from zero. So does a cycle in which the pending count is 0. After either, L fresh starved cycles are needed to go critical.
- R5: When the flag rises, the quota Q is taken as the smaller of the run length and the pending count. The flag stays high through the first Q-1 service pulses. It clears at the edge that takes the Q-th pulse.
- R6: With a run length of 0, the critical flag is high for exactly one cycle and then clears without any service.
- R7: If the pending count is 0 while the flag is high, the flag clears at the next edge.
- R8: The queues use indices 0 (high-priority read), 1 (low-priority read) and 2 (write). Each queue has its own limit, run length and state. Starving one queue never changes another queue's flag.
- R9: The starved count is held at zero while a queue is critical. After the flag clears, a still-starved queue needs a full L cycles to go critical again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_cnt | input | NUM_Q x PEND_W | Pending transactions in each queue |
| svc_pulse | input | NUM_Q | One-cycle pulse per transaction serviced from the queue |
| starve_limit | input | NUM_Q x LIMIT_W | Starved cycles before going critical; 0 turns the watchdog off |
| run_length | input | NUM_Q x RUN_W | Upper bound on services granted while critical |
| critical | output | NUM_Q | Critical flag per queue |

## Verification
A table of cases drives one queue at a time through a complete cycle. Each case starves the queue, checks that the flag rises on the exact limit edge and then counts service pulses down to the clear. The cases are chosen so that the run length sometimes binds and the pending count sometimes binds, which tells a correct minimum apart from either operand alone. One case uses a run length of 0 and one uses the largest limit, to catch counter width and off-by-one errors. Directed sequences then interrupt starvation with a service pulse or an empty queue, drain a critical queue to empty, and starve two queues with different limits, which tells count restarts and queue independence apart from a shared or sticky counter.

// File: rtl/starve_pkg.sv
package starve_pkg;
  parameter int NUM_QUEUES = 3;
  parameter int LIMIT_BITS = 16;
  parameter int RUN_BITS   = 8;
  parameter int PEND_BITS  = 7;

  typedef enum logic [1:0] {
    Q_HPR = 2'd0,
    Q_LPR = 2'd1,
    Q_WR  = 2'd2
  } queue_id_e;
endpackage

// File: rtl/starve_timer.sv
module starve_timer #(
  parameter int LIMIT_W = 16,
  parameter int PEND_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PEND_W-1:0]  pend,
  input  logic               svc,
  input  logic [LIMIT_W-1:0] lim,
  input  logic               crit,
  output logic               trip
);
  logic [LIMIT_W-1:0] cnt;
  logic               starved;
  logic               armed;

  assign starved = (pend != '0) && !svc;
  assign armed   = (lim != '0);
  assign trip    = starved && armed && !crit && (cnt == lim - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!starved || !armed || crit || trip)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  // R4
  restart_on_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc || pend == '0) |=> (cnt == '0));

  // R9
  hold_while_critical_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crit |-> (cnt == '0));

  // R3
  no_trip_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lim == '0) |-> !trip);
endmodule

// File: rtl/run_budget.sv
module run_budget #(
  parameter int RUN_W  = 8,
  parameter int PEND_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip,
  input  logic [PEND_W-1:0] pend,
  input  logic              svc,
  input  logic [RUN_W-1:0]  run_len,
  output logic              crit
);
  localparam int CMP_W = (RUN_W > PEND_W) ? RUN_W : PEND_W;

  function automatic logic [RUN_W-1:0] quota_of(input logic [RUN_W-1:0] run,
                                                input logic [PEND_W-1:0] avail);
    logic [CMP_W-1:0] r_ext;
    logic [CMP_W-1:0] a_ext;
    r_ext = CMP_W'(run);
    a_ext = CMP_W'(avail);
    return (a_ext < r_ext) ? RUN_W'(a_ext) : run;
  endfunction

  logic [RUN_W-1:0] rem;
  logic             finish;

  assign finish = (pend == '0) || (rem == '0) || (svc && rem == RUN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit <= 1'b0;
      rem  <= '0;
    end else if (trip) begin
      crit <= 1'b1;
      rem  <= quota_of(run_len, pend);
    end else if (crit) begin
      if (finish) begin
        crit <= 1'b0;
        rem  <= '0;
      end else if (svc) begin
        rem <= rem - 1'b1;
      end
    end
  end

  // R2
  rise_needs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crit) |-> $past(trip));

  // R6
  empty_quota_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit && rem == '0 && !trip) |=> !crit);

  // R7
  drained_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crit && pend == '0) |=> !crit);

  // R5
  fall_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crit) |-> $past(pend == '0 || rem <= RUN_W'(1)));
endmodule

// File: rtl/queue_starve_guard.sv
module queue_starve_guard #(
  parameter int NUM_Q   = starve_pkg::NUM_QUEUES,
  parameter int LIMIT_W = starve_pkg::LIMIT_BITS,
  parameter int RUN_W   = starve_pkg::RUN_BITS,
  parameter int PEND_W  = starve_pkg::PEND_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_Q-1:0][PEND_W-1:0]  pend_cnt,
  input  logic [NUM_Q-1:0]              svc_pulse,
  input  logic [NUM_Q-1:0][LIMIT_W-1:0] starve_limit,
  input  logic [NUM_Q-1:0][RUN_W-1:0]   run_length,
  output logic [NUM_Q-1:0]              critical
);
  logic [NUM_Q-1:0] trip_w;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    starve_timer #(.LIMIT_W(LIMIT_W), .PEND_W(PEND_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend_cnt[q]),
      .svc   (svc_pulse[q]),
      .lim   (starve_limit[q]),
      .crit  (critical[q]),
      .trip  (trip_w[q])
    );

    run_budget #(.RUN_W(RUN_W), .PEND_W(PEND_W)) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip    (trip_w[q]),
      .pend    (pend_cnt[q]),
      .svc     (svc_pulse[q]),
      .run_len (run_length[q]),
      .crit    (critical[q])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (critical == '0));
endmodule

// File: tb/queue_starve_guard_test.sv
module queue_starve_guard_test;
  import starve_pkg::*;

  localparam int NQ = NUM_QUEUES;
  localparam int NV = 6;
  // columns: queue, limit, run length, pending count
  localparam int VEC [NV][4] = '{
    '{0, 5,     3,   10},
    '{1, 1,     4,   2},
    '{2, 20,    0,   6},
    '{0, 300,   255, 64},
    '{2, 2,     1,   1},
    '{1, 65535, 2,   9}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NQ-1:0][PEND_BITS-1:0]  pend_cnt = '0;
  logic [NQ-1:0]                 svc_pulse = '0;
  logic [NQ-1:0][LIMIT_BITS-1:0] starve_limit = '0;
  logic [NQ-1:0][RUN_BITS-1:0]   run_length = '0;
  logic [NQ-1:0]                 critical;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  queue_starve_guard uut (
    .clk, .rst_n, .pend_cnt, .svc_pulse, .starve_limit, .run_length, .critical
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    step(3);
    chk("R1 in reset", int'(critical), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after release", int'(critical), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int q, lim, run, pend, quota;
      q = VEC[v][0]; lim = VEC[v][1]; run = VEC[v][2]; pend = VEC[v][3];
      quota = (run < pend) ? run : pend;
      pend_cnt = '0; svc_pulse = '0; starve_limit = '0; run_length = '0;
      step(2);
      starve_limit[q] = LIMIT_BITS'(lim);
      run_length[q]   = RUN_BITS'(run);
      pend_cnt[q]     = PEND_BITS'(pend);
      if (lim > 1) begin
        step(lim - 1);
        chk("R2 one short of limit", int'(critical[q]), 0);
        step(1);
      end else begin
        step(1);
      end
      chk("R2 critical on limit", int'(critical[q]), 1);
      if (quota == 0) begin
        step(1);
        chk("R6 zero run pulse", int'(critical[q]), 0);
      end else begin
        svc_pulse[q] = 1'b1;
        if (quota > 1) begin
          step(quota - 1);
          chk("R5 held before last service", int'(critical[q]), 1);
        end
        step(1);
        svc_pulse[q] = 1'b0;
        chk("R5 cleared by last service", int'(critical[q]), 0);
      end
      if (lim < 1000) begin
        if (lim > 1) begin
          step(lim - 1);
          chk("R9 restart after critical", int'(critical[q]), 0);
        end
        step(1);
        chk("R9 critical again", int'(critical[q]), 1);
      end
    end

    // R3: disabled watchdog
    pend_cnt = '0; svc_pulse = '0; starve_limit = '0; run_length = '0;
    rst_n = 1'b0; step(1); rst_n = 1'b1; step(1);
    pend_cnt[Q_LPR] = 7'd5;
    run_length[Q_LPR] = 8'd3;
    step(400);
    chk("R3 limit zero never critical", int'(critical), 0);

    // R4: service restarts count
    pend_cnt = '0;
    starve_limit[Q_HPR] = 16'd10;
    run_length[Q_HPR] = 8'd4;
    pend_cnt[Q_HPR] = 7'd3;
    step(9);
    svc_pulse[Q_HPR] = 1'b1; step(1); svc_pulse[Q_HPR] = 1'b0;
    step(9);
    chk("R4 service restarts count", int'(critical[Q_HPR]), 0);
    step(1);
    chk("R4 full limit after service", int'(critical[Q_HPR]), 1);
    // R7: drain while critical
    pend_cnt[Q_HPR] = 7'd0; step(1);
    chk("R7 empty clears critical", int'(critical[Q_HPR]), 0);
    // R4: empty restarts count
    pend_cnt[Q_HPR] = 7'd3; step(9);
    pend_cnt[Q_HPR] = 7'd0; step(1);
    pend_cnt[Q_HPR] = 7'd3; step(9);
    chk("R4 empty restarts count", int'(critical[Q_HPR]), 0);
    step(1);
    chk("R4 full limit after empty", int'(critical[Q_HPR]), 1);
    pend_cnt[Q_HPR] = 7'd0; step(1);

    // R8: independent queues
    starve_limit[Q_HPR] = 16'd4;
    starve_limit[Q_WR]  = 16'd7;
    run_length[Q_WR]    = 8'd2;
    pend_cnt[Q_HPR] = 7'd2;
    pend_cnt[Q_WR]  = 7'd2;
    step(4);
    chk("R8 only queue 0 critical", int'(critical), 1);
    step(3);
    chk("R8 queue 2 joins", int'(critical), 5);
    svc_pulse[Q_WR] = 1'b1; step(2); svc_pulse[Q_WR] = 1'b0;
    chk("R8 queue 2 done, queue 0 held", int'(critical), 1);

    summary();
  end
endmodule